// File: doc/BRIEF.md
# Dual-Clock Mailbox Register

This block carries one message word from a writer port to a reader port that runs on an unrelated clock, beside a FIFO and not through it. The writer picks the mailbox with its select input. A strobe with that select high stores the word, provided the mailbox is free. A strobe with the select low is passed on as a FIFO write request. On the reader side, a strobe with the select high takes the mailbox word into the output register. A strobe with the select low passes a FIFO read request and loads the FIFO's output-register data instead.

Occupancy is tracked with two toggle bits, one owned by each clock domain, and each bit is carried into the other domain through a flop chain. Each side derives its own active-low full flag from its own toggle and the synchronized copy of the other side's toggle. The writer's flag falls on the edge that stores the word and blocks further stores. The reader's flag rises on the edge that consumes the word. Each flag learns of the other side's event after the synchronizer delay. A master reset clears everything. A partial reset clears the handshake and the output register but keeps the stored words.

Top module: `mbx_xclk`

## Requirements
- R1: A writer edge with wr_en=1, wr_mbx_sel=1 and wr_full_n=1 stores wr_data and drives wr_full_n low after that edge. rd_full_n goes low after the second following reader edge.
- R2: While wr_full_n is low, writer strobes with wr_mbx_sel=1 leave the stored word unchanged and keep wr_full_n low. A later mailbox read returns the first word.
- R3: A reader edge with rd_en=1, rd_mbx_sel=1 and rd_full_n=0 loads the stored word into rd_data and drives rd_full_n high after that edge. wr_full_n goes high after the second following writer edge.
- R4: While mst_rst_n is low, wr_full_n and rd_full_n are high and rd_data is zero. A mailbox read after release returns zero.
- R5: While prt_rst_n is low, both flags are high and rd_data is zero. After release, a mailbox read returns the last word consumed before the reset, and a new write is accepted.
- R6: A reader edge with rd_en=1 and rd_mbx_sel=0 loads fifo_rd_data into rd_data and leaves rd_full_n unchanged. fifo_rd_en equals rd_en AND NOT rd_mbx_sel, combinationally.
- R7: fifo_wr_en equals wr_en AND NOT wr_mbx_sel, combinationally, so a mailbox write never reaches the FIFO.
- R8: A reader edge with rd_en=1, rd_mbx_sel=1 and rd_full_n=1 loads the last consumed word into rd_data and leaves rd_full_n high.
- R9: Reader edges with rd_en=0 leave rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer clock |
| rd_clk | input | 1 | Reader clock |
| mst_rst_n | input | 1 | Asynchronous master reset, active low |
| prt_rst_n | input | 1 | Asynchronous partial reset, active low |
| wr_en | input | 1 | Writer strobe |
| wr_mbx_sel | input | 1 | Writer target: 1 mailbox, 0 FIFO |
| wr_data | input | 36 | Writer data |
| fifo_wr_en | output | 1 | Write request passed to the FIFO |
| wr_full_n | output | 1 | Writer-domain mailbox flag, low when occupied |
| rd_en | input | 1 | Reader strobe |
| rd_mbx_sel | input | 1 | Reader source: 1 mailbox, 0 FIFO |
| fifo_rd_data | input | 36 | FIFO output-register data |
| fifo_rd_en | output | 1 | Read request passed to the FIFO |
| rd_data | output | 36 | Reader output register |
| rd_full_n | output | 1 | Reader-domain mailbox flag, low when a word waits |

## Verification
Results in the strobe's own domain are due on that domain's next edge: rd_data, the local flag after a write or a consume, and the FIFO requests, which are combinational and due at once. The other domain's flag is due after two of its own edges. The bench runs the reader clock 3 ns behind the writer clock at the same rate, so that crossing lands on a fixed edge. It samples every result on the falling edge of the clock of the domain that owns it, checks once one edge before the flag is due that the flag has not yet changed, and checks again on the edge where the change is due.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_DATA_W  = 36;
    localparam int unsigned MBX_SYNC_N  = 2;

    // Flag is high (free) when both toggles agree.
    function automatic logic mbx_free(input logic own_tog, input logic far_tog);
        return own_tog == far_tog;
    endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
    import mbx_pkg::*;
#(
    parameter int unsigned DW   = MBX_DATA_W,
    parameter int unsigned SYNC = MBX_SYNC_N
) (
    input  logic          clk,
    input  logic          mst_rst_n,
    input  logic          prt_rst_n,
    input  logic          wr_en,
    input  logic          mbx_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          far_tog,
    output logic          own_tog,
    output logic [DW-1:0] mbx_word,
    output logic          full_n,
    output logic          fifo_wr_en
);
    typedef struct packed {
        logic tog;
    } ctl_t;

    typedef struct packed {
        logic [DW-1:0] word;
    } keep_t;

    logic  hs_rst_n;
    logic  far_tog_s;
    logic  accept;
    ctl_t  ctl_d, ctl_q;
    keep_t keep_d, keep_q;

    assign hs_rst_n = mst_rst_n & prt_rst_n;

    mbx_sync #(.STAGES(SYNC)) u_sync_rd_tog (
        .clk   (clk),
        .rst_n (hs_rst_n),
        .d     (far_tog),
        .q     (far_tog_s)
    );

    always_comb begin
        ctl_d  = ctl_q;
        keep_d = keep_q;
        full_n = mbx_free(ctl_q.tog, far_tog_s);
        accept = wr_en & mbx_sel & full_n;
        if (accept) begin
            ctl_d.tog   = ~ctl_q.tog;
            keep_d.word = wr_data;
        end
        fifo_wr_en = wr_en & ~mbx_sel;
    end

    always_ff @(posedge clk or negedge hs_rst_n) begin
        if (!hs_rst_n) ctl_q <= '0;
        else           ctl_q <= ctl_d;
    end

    always_ff @(posedge clk or negedge mst_rst_n) begin
        if (!mst_rst_n) keep_q <= '0;
        else            keep_q <= keep_d;
    end

    assign own_tog  = ctl_q.tog;
    assign mbx_word = keep_q.word;

    assert_full_drop_R1: assert property (@(posedge clk) disable iff (!hs_rst_n)
        (wr_en && mbx_sel && full_n) |=> !full_n);

    assert_write_blocked_R2: assert property (@(posedge clk) disable iff (!hs_rst_n)
        (wr_en && mbx_sel && !full_n) |=> ($stable(mbx_word) && !full_n));

    assert_fifo_wr_route_R7: assert property (@(posedge clk) disable iff (!hs_rst_n)
        (wr_en && mbx_sel) |-> !fifo_wr_en);
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side
    import mbx_pkg::*;
#(
    parameter int unsigned DW   = MBX_DATA_W,
    parameter int unsigned SYNC = MBX_SYNC_N
) (
    input  logic          clk,
    input  logic          mst_rst_n,
    input  logic          prt_rst_n,
    input  logic          rd_en,
    input  logic          mbx_sel,
    input  logic [DW-1:0] mbx_word,
    input  logic [DW-1:0] fifo_data,
    input  logic          far_tog,
    output logic          own_tog,
    output logic [DW-1:0] rd_data,
    output logic          full_n,
    output logic          fifo_rd_en
);
    typedef struct packed {
        logic          tog;
        logic [DW-1:0] out;
    } ctl_t;

    typedef struct packed {
        logic [DW-1:0] last;
    } keep_t;

    logic  hs_rst_n;
    logic  far_tog_s;
    logic  consume;
    ctl_t  ctl_d, ctl_q;
    keep_t keep_d, keep_q;

    assign hs_rst_n = mst_rst_n & prt_rst_n;

    mbx_sync #(.STAGES(SYNC)) u_sync_wr_tog (
        .clk   (clk),
        .rst_n (hs_rst_n),
        .d     (far_tog),
        .q     (far_tog_s)
    );

    always_comb begin
        ctl_d   = ctl_q;
        keep_d  = keep_q;
        full_n  = mbx_free(ctl_q.tog, far_tog_s);
        consume = rd_en & mbx_sel & ~full_n;
        if (consume) begin
            ctl_d.tog   = ~ctl_q.tog;
            keep_d.last = mbx_word;
        end
        if (rd_en) begin
            if (mbx_sel) ctl_d.out = consume ? mbx_word : keep_q.last;
            else         ctl_d.out = fifo_data;
        end
        fifo_rd_en = rd_en & ~mbx_sel;
    end

    always_ff @(posedge clk or negedge hs_rst_n) begin
        if (!hs_rst_n) ctl_q <= '0;
        else           ctl_q <= ctl_d;
    end

    always_ff @(posedge clk or negedge mst_rst_n) begin
        if (!mst_rst_n) keep_q <= '0;
        else            keep_q <= keep_d;
    end

    assign own_tog = ctl_q.tog;
    assign rd_data = ctl_q.out;

    assert_consume_R3: assert property (@(posedge clk) disable iff (!hs_rst_n)
        (rd_en && mbx_sel && !full_n) |=> (full_n && rd_data == $past(mbx_word)));

    assert_fifo_route_R6: assert property (@(posedge clk) disable iff (!hs_rst_n)
        (rd_en && !mbx_sel) |=> (rd_data == $past(fifo_data) && full_n == $past(full_n)));

    assert_stale_flag_R8: assert property (@(posedge clk) disable iff (!hs_rst_n)
        (rd_en && mbx_sel && full_n) |=> full_n);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!hs_rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/mbx_xclk.sv
module mbx_xclk
    import mbx_pkg::*;
#(
    parameter int unsigned DW   = MBX_DATA_W,
    parameter int unsigned SYNC = MBX_SYNC_N
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mst_rst_n,
    input  logic          prt_rst_n,
    input  logic          wr_en,
    input  logic          wr_mbx_sel,
    input  logic [DW-1:0] wr_data,
    output logic          fifo_wr_en,
    output logic          wr_full_n,
    input  logic          rd_en,
    input  logic          rd_mbx_sel,
    input  logic [DW-1:0] fifo_rd_data,
    output logic          fifo_rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_full_n
);
    logic          wr_tog, rd_tog;
    logic [DW-1:0] mbx_word;

    mbx_wr_side #(.DW(DW), .SYNC(SYNC)) u_wr (
        .clk        (wr_clk),
        .mst_rst_n  (mst_rst_n),
        .prt_rst_n  (prt_rst_n),
        .wr_en      (wr_en),
        .mbx_sel    (wr_mbx_sel),
        .wr_data    (wr_data),
        .far_tog    (rd_tog),
        .own_tog    (wr_tog),
        .mbx_word   (mbx_word),
        .full_n     (wr_full_n),
        .fifo_wr_en (fifo_wr_en)
    );

    mbx_rd_side #(.DW(DW), .SYNC(SYNC)) u_rd (
        .clk        (rd_clk),
        .mst_rst_n  (mst_rst_n),
        .prt_rst_n  (prt_rst_n),
        .rd_en      (rd_en),
        .mbx_sel    (rd_mbx_sel),
        .mbx_word   (mbx_word),
        .fifo_data  (fifo_rd_data),
        .far_tog    (wr_tog),
        .own_tog    (rd_tog),
        .rd_data    (rd_data),
        .full_n     (rd_full_n),
        .fifo_rd_en (fifo_rd_en)
    );

    always @(posedge rd_clk) begin
        if (mst_rst_n && prt_rst_n)
            assert_reader_flag_R1: assert (!(wr_full_n && !rd_full_n && wr_tog == rd_tog))
                else $display("R1 flag mismatch");
    end
endmodule

// File: tb/mbx_xclk_tb.sv
module mbx_xclk_tb_top;
    localparam int DW = 36;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          mst_rst_n = 1'b0, prt_rst_n = 1'b1;
    logic          wr_en = 1'b0, wr_mbx_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          fifo_wr_en, wr_full_n;
    logic          rd_en = 1'b0, rd_mbx_sel = 1'b0;
    logic [DW-1:0] fifo_rd_data = '0;
    logic          fifo_rd_en, rd_full_n;
    logic [DW-1:0] rd_data;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #4 rd_clk = ~rd_clk;
    end

    mbx_xclk dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mst_rst_n(mst_rst_n), .prt_rst_n(prt_rst_n),
        .wr_en(wr_en), .wr_mbx_sel(wr_mbx_sel), .wr_data(wr_data),
        .fifo_wr_en(fifo_wr_en), .wr_full_n(wr_full_n),
        .rd_en(rd_en), .rd_mbx_sel(rd_mbx_sel), .fifo_rd_data(fifo_rd_data),
        .fifo_rd_en(fifo_rd_en), .rd_data(rd_data), .rd_full_n(rd_full_n)
    );

    // Each entry: {mailbox word, FIFO word}
    localparam logic [2*DW-1:0] VEC [6] = '{
        {36'h0_0000_0001, 36'hF_FFFF_FFFF},
        {36'hA_5A5A_5A5A, 36'h5_A5A5_A5A5},
        {36'hF_FFFF_FFFF, 36'h0_0000_0000},
        {36'h1_2345_6789, 36'h9_8765_4321},
        {36'h8_0000_0000, 36'h0_0000_0001},
        {36'h0_DEAD_BEEF, 36'hC_AFE0_0123}
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [DW-1:0] data);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_mbx_sel = sel; wr_data = data;
        @(negedge wr_clk);
        wr_en = 1'b0; wr_mbx_sel = 1'b0;
    endtask

    task automatic do_read(input logic sel, input logic [DW-1:0] fdata);
        @(negedge rd_clk);
        rd_en = 1'b1; rd_mbx_sel = sel; fifo_rd_data = fdata;
        @(negedge rd_clk);
        rd_en = 1'b0; rd_mbx_sel = 1'b0;
    endtask

    task automatic wait_rd_flag_low();
        @(negedge rd_clk);
        @(negedge rd_clk);
    endtask

    task automatic wait_wr_flag_high();
        @(negedge wr_clk);
        @(negedge wr_clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        // R4: state during master reset
        repeat (3) @(negedge wr_clk);
        check("R4 wr_full_n in reset", {35'd0, wr_full_n}, 36'd1);
        check("R4 rd_full_n in reset", {35'd0, rd_full_n}, 36'd1);
        check("R4 rd_data in reset", rd_data, '0);
        mst_rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
        do_read(1'b1, 36'h1_1111_1111);
        check("R4 stale word after master reset", rd_data, '0);

        // Table walk: R1, R3, R6
        foreach (VEC[i]) begin
            logic [DW-1:0] mw, fw;
            mw = VEC[i][2*DW-1:DW];
            fw = VEC[i][DW-1:0];
            do_write(1'b1, mw);
            check("R1 wr_full_n low after write", {35'd0, wr_full_n}, 36'd0);
            @(negedge rd_clk);
            check("R1 rd_full_n not yet low", {35'd0, rd_full_n}, 36'd1);
            @(negedge rd_clk);
            check("R1 rd_full_n low", {35'd0, rd_full_n}, 36'd0);
            do_read(1'b0, fw);
            check("R6 fifo data loaded", rd_data, fw);
            check("R6 rd_full_n unchanged", {35'd0, rd_full_n}, 36'd0);
            do_read(1'b1, fw);
            check("R3 mailbox word read", rd_data, mw);
            check("R3 rd_full_n high", {35'd0, rd_full_n}, 36'd1);
            @(negedge wr_clk);
            check("R3 wr_full_n not yet high", {35'd0, wr_full_n}, 36'd0);
            @(negedge wr_clk);
            check("R3 wr_full_n high", {35'd0, wr_full_n}, 36'd1);
        end

        // R7 / R6: combinational FIFO request routing
        @(negedge wr_clk);
        wr_en = 1'b1; wr_mbx_sel = 1'b0; #1;
        check("R7 fifo_wr_en on FIFO write", {35'd0, fifo_wr_en}, 36'd1);
        wr_mbx_sel = 1'b1; wr_en = 1'b0; #1;
        check("R7 fifo_wr_en idle", {35'd0, fifo_wr_en}, 36'd0);
        wr_mbx_sel = 1'b0;
        @(negedge rd_clk);
        rd_en = 1'b1; rd_mbx_sel = 1'b1; #1;
        check("R6 fifo_rd_en off for mailbox read", {35'd0, fifo_rd_en}, 36'd0);
        rd_mbx_sel = 1'b0; #1;
        check("R6 fifo_rd_en on for FIFO read", {35'd0, fifo_rd_en}, 36'd1);
        rd_en = 1'b0;

        // R2: blocked overwrite, R7: mailbox write does not reach FIFO
        do_write(1'b1, 36'h3_3333_3333);
        @(negedge wr_clk);
        wr_en = 1'b1; wr_mbx_sel = 1'b1; wr_data = 36'h4_4444_4444; #1;
        check("R7 fifo_wr_en low on mailbox write", {35'd0, fifo_wr_en}, 36'd0);
        @(negedge wr_clk);
        wr_en = 1'b0; wr_mbx_sel = 1'b0;
        check("R2 wr_full_n stays low", {35'd0, wr_full_n}, 36'd0);
        wait_rd_flag_low();
        do_read(1'b1, '0);
        check("R2 first word kept", rd_data, 36'h3_3333_3333);
        wait_wr_flag_high();

        // R8: stale read after FIFO read
        do_read(1'b0, 36'h7_7777_7777);
        do_read(1'b1, '0);
        check("R8 stale word", rd_data, 36'h3_3333_3333);
        check("R8 rd_full_n stays high", {35'd0, rd_full_n}, 36'd1);

        // R9: idle reader edges hold rd_data
        fifo_rd_data = 36'h6_6666_6666;
        repeat (3) @(negedge rd_clk);
        check("R9 rd_data held", rd_data, 36'h3_3333_3333);

        // R5: partial reset with a word pending
        do_write(1'b1, 36'h5_5555_5555);
        wait_rd_flag_low();
        @(negedge wr_clk);
        prt_rst_n = 1'b0;
        @(negedge wr_clk);
        check("R5 wr_full_n high in partial reset", {35'd0, wr_full_n}, 36'd1);
        check("R5 rd_full_n high in partial reset", {35'd0, rd_full_n}, 36'd1);
        check("R5 rd_data zero in partial reset", rd_data, '0);
        prt_rst_n = 1'b1;
        repeat (2) @(negedge wr_clk);
        do_read(1'b1, '0);
        check("R5 last consumed word retained", rd_data, 36'h3_3333_3333);
        do_write(1'b1, 36'h2_2222_2222);
        check("R5 write accepted after partial reset", {35'd0, wr_full_n}, 36'd0);
        wait_rd_flag_low();
        do_read(1'b1, '0);
        check("R5 new word read", rd_data, 36'h2_2222_2222);

        done = 1'b1;
        finish_run();
    end
endmodule